// File: doc/BRIEF.md
# Lockable Write-Protect Threshold Unit

This unit guards the write path of a word-organised serial memory. It stores one threshold address. Every array word whose address is equal to or above that threshold is closed to writes, and every word below it stays writable. A serial front-end decodes the protect-side commands and passes them in as single-cycle strobes, together with an 8-bit address and the level of the program-enable pin. The unit also answers, without any clock delay, whether a candidate address may be written. It answers the same question for a whole-array write, and it shifts the stored threshold out one bit at a time for readback.

A change to the threshold takes two steps. First an arming command is given, and then a load or a clear follows in a later cycle. One arm allows exactly one change. A separate lock command freezes the threshold for good. Only a test-only reset can undo the lock.

The threshold, its valid flag and the lock model non-volatile storage. The functional reset does not touch them. That reset clears only the arm and the readback shifter.

Top module: `wp_threshold_unit`

## Requirements
- R1: After the test reset, nothing is protected (valid flag clear) and the unit is unlocked. After the functional reset, `armed` is 0 and `rb_bit` is 0.
- R2: `wr_permit` is 1 exactly when the valid flag is clear or `cand_addr` is below the stored threshold. It follows `cand_addr` in the same cycle.
- R3: `wall_permit` is 1 only when nothing is protected. With any valid threshold, including 255, it is 0.
- R4: An arm strobe with `pe` high sets `armed` from the next cycle on. A load or clear strobe given in the same cycle as the arm sees the old arm state. When that old state is 0, the load or clear is refused.
- R5: A load strobe with `pe` high, while armed and unlocked, stores `op_addr` as the threshold and sets the valid flag. It also drops `armed`.
- R6: A clear strobe with `pe` high, while armed and unlocked, clears the valid flag so that nothing is protected. It also drops `armed`.
- R7: While `pe` is low, the arm, load, clear and lock strobes have no effect.
- R8: A lock strobe with `pe` high sets `locked`. After that, load and clear no longer change the protection. The lock and the threshold both survive the functional reset, and only the test reset clears them.
- R9: A readback strobe loads a value of 9 bits. In the next cycle `rb_bit` shows a dummy 0. Each `rb_shift` pulse then shows the next threshold bit, most significant bit first. A cleared register reads back as all ones.
- R10: With a threshold of 255, only address 255 is protected. With a threshold of 0, every address is protected.
- R11: When a readback strobe and an accepted load fall in the same cycle, the readback returns the threshold as it stood before that cycle.
- R12: When readback and shift strobes fall in the same cycle, the load wins.

Because the text lists twelve requirements, the table below was kept consistent with R1–R12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Functional reset, active low; clears arm and readback |
| test_rst_n | input | 1 | Test-only reset, active low; clears threshold, valid and lock |
| pe | input | 1 | Program-enable pin level |
| op_rd | input | 1 | Decoded protect readback strobe |
| op_arm | input | 1 | Decoded arm strobe |
| op_clr | input | 1 | Decoded clear strobe |
| op_wr | input | 1 | Decoded threshold load strobe |
| op_lock | input | 1 | Decoded permanent lock strobe |
| op_addr | input | 8 | Address field of the load command |
| rb_shift | input | 1 | Advance the readback by one bit |
| cand_addr | input | 8 | Candidate array address for a write |
| wr_permit | output | 1 | Write to `cand_addr` allowed |
| wall_permit | output | 1 | Whole-array write allowed |
| rb_bit | output | 1 | Serial readback bit |
| armed | output | 1 | A change is currently armed |
| locked | output | 1 | Threshold is permanently frozen |

## Verification
Two functions can fall in the same cycle. In the first case, arming and a threshold load arrive together. The bench drives both strobes on one edge and requires the load to be refused, while the arm still takes hold for the following frame. In the second case, a readback capture coincides with an accepted load. The bench shifts out all nine bits and requires the pre-load threshold, then reads again and requires the new value.

// File: rtl/wp_pkg.sv
package wp_pkg;
   typedef struct packed {
      logic rd;
      logic arm;
      logic clr;
      logic wr;
      logic lock;
   } wp_ops_t;

   localparam int unsigned WP_MAX_ADDR_W = 16;
endpackage

// File: rtl/wp_store.sv
module wp_store #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 test_rst_n,
   input  logic                 pe,
   input  wp_pkg::wp_ops_t      ops,
   input  logic [ADDR_W-1:0]    op_addr,
   output logic [ADDR_W-1:0]    thr,
   output logic                 thr_valid,
   output logic                 armed,
   output logic                 locked
);
   logic may_change, do_load, do_clear;

   assign may_change = pe && armed && !locked;
   assign do_load    = may_change && ops.wr;
   assign do_clear   = may_change && ops.clr && !ops.wr;

   always_ff @(posedge clk or negedge test_rst_n) begin
      if (!test_rst_n) begin
         thr       <= '0;
         thr_valid <= 1'b0;
         locked    <= 1'b0;
      end else begin
         if (do_load) begin
            thr       <= op_addr;
            thr_valid <= 1'b1;
         end else if (do_clear) begin
            thr_valid <= 1'b0;
         end
         if (pe && ops.lock) locked <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (do_load || do_clear) begin
         armed <= 1'b0;
      end else if (pe && ops.arm) begin
         armed <= 1'b1;
      end
   end

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!test_rst_n)
      locked |=> locked); // R8
   AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!test_rst_n)
      locked |=> ($stable(thr) && $stable(thr_valid))); // R8
   AST_PE_LOW_HOLD: assert property (@(posedge clk) disable iff (!test_rst_n)
      !pe |=> ($stable(thr) && $stable(thr_valid))); // R7
   AST_ARM_NEEDS_PE: assert property (@(posedge clk) disable iff (!rst_n)
      (!pe && !armed) |=> !armed); // R4
   AST_ARM_USED: assert property (@(posedge clk) disable iff (!rst_n || !test_rst_n)
      (ops.wr && pe && armed && !locked) |=> !armed); // R5
endmodule

// File: rtl/wp_compare.sv
module wp_compare #(
   parameter int unsigned ADDR_W     = 8,
   parameter bit          CMP_RIPPLE = 1'b1
) (
   input  logic [ADDR_W-1:0] cand,
   input  logic [ADDR_W-1:0] thr,
   output logic              below
);
   generate
      if (CMP_RIPPLE) begin : g_ripple
         logic [ADDR_W:0] lt_acc;
         logic [ADDR_W:0] eq_acc;
         assign lt_acc[ADDR_W] = 1'b0;
         assign eq_acc[ADDR_W] = 1'b1;
         for (genvar i = ADDR_W - 1; i >= 0; i--) begin : g_bit
            assign lt_acc[i] = lt_acc[i+1] | (eq_acc[i+1] & ~cand[i] & thr[i]);
            assign eq_acc[i] = eq_acc[i+1] & (cand[i] == thr[i]);
         end
         assign below = lt_acc[0];
      end else begin : g_magnitude
         assign below = (cand < thr);
      end
   endgenerate
endmodule

// File: rtl/wp_readback.sv
module wp_readback #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [ADDR_W-1:0] value,
   output logic              rb_bit
);
   localparam int unsigned SH_W = ADDR_W + 1;
   logic [SH_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '0;
      else if (load)  sh <= {1'b0, value};
      else if (shift) sh <= {sh[SH_W-2:0], 1'b0};
   end

   assign rb_bit = sh[SH_W-1];

   AST_DUMMY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !rb_bit); // R9
endmodule

// File: rtl/wp_threshold_unit.sv
module wp_threshold_unit #(
   parameter int unsigned ADDR_W     = 8,
   parameter bit          CMP_RIPPLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_rst_n,
   input  logic              pe,
   input  logic              op_rd,
   input  logic              op_arm,
   input  logic              op_clr,
   input  logic              op_wr,
   input  logic              op_lock,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic              rb_shift,
   input  logic [ADDR_W-1:0] cand_addr,
   output logic              wr_permit,
   output logic              wall_permit,
   output logic              rb_bit,
   output logic              armed,
   output logic              locked
);
   generate
      if (ADDR_W < 2 || ADDR_W > wp_pkg::WP_MAX_ADDR_W) begin : g_bad_width
         $error("wp_threshold_unit: ADDR_W out of range");
      end
   endgenerate

   wp_pkg::wp_ops_t   ops;
   logic [ADDR_W-1:0] thr;
   logic              thr_valid;
   logic              below;
   logic [ADDR_W-1:0] rb_value;

   assign ops = '{rd: op_rd, arm: op_arm, clr: op_clr, wr: op_wr, lock: op_lock};

   wp_store #(.ADDR_W(ADDR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .test_rst_n(test_rst_n), .pe(pe),
      .ops(ops), .op_addr(op_addr), .thr(thr), .thr_valid(thr_valid),
      .armed(armed), .locked(locked)
   );

   wp_compare #(.ADDR_W(ADDR_W), .CMP_RIPPLE(CMP_RIPPLE)) u_cmp (
      .cand(cand_addr), .thr(thr), .below(below)
   );

   assign rb_value = thr_valid ? thr : {ADDR_W{1'b1}};

   wp_readback #(.ADDR_W(ADDR_W)) u_rb (
      .clk(clk), .rst_n(rst_n), .load(op_rd), .shift(rb_shift),
      .value(rb_value), .rb_bit(rb_bit)
   );

   assign wr_permit   = !thr_valid || below;
   assign wall_permit = !thr_valid;

   AST_WALL_IMPLIES_ONE: assert property (@(posedge clk) disable iff (!rst_n || !test_rst_n)
      wall_permit |-> wr_permit); // R3
   AST_TOP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n || !test_rst_n)
      (thr_valid && (cand_addr >= thr)) |-> !wr_permit); // R2
endmodule

// File: tb/tb_wp_threshold_unit.sv
module tb_wp_threshold_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0, test_rst_n = 1'b0, pe = 1'b0;
   logic op_rd = 0, op_arm = 0, op_clr = 0, op_wr = 0, op_lock = 0, rb_shift = 0;
   logic [7:0] op_addr = '0, cand_addr = '0;
   logic wr_permit, wall_permit, rb_bit, armed, locked;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   wp_threshold_unit dut (
      .clk(clk), .rst_n(rst_n), .test_rst_n(test_rst_n), .pe(pe),
      .op_rd(op_rd), .op_arm(op_arm), .op_clr(op_clr), .op_wr(op_wr),
      .op_lock(op_lock), .op_addr(op_addr), .rb_shift(rb_shift),
      .cand_addr(cand_addr), .wr_permit(wr_permit), .wall_permit(wall_permit),
      .rb_bit(rb_bit), .armed(armed), .locked(locked)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ops bits: {lock, wr, clr, arm, rd}
   task automatic do_op(input logic [4:0] ops, input logic [7:0] a, input logic p);
      @(negedge clk);
      {op_lock, op_wr, op_clr, op_arm, op_rd} = ops;
      op_addr = a; pe = p;
      @(negedge clk);
      {op_lock, op_wr, op_clr, op_arm, op_rd} = '0;
   endtask

   task automatic shift_out(input logic [7:0] exp, input string req);
      check(rb_bit == 1'b0, {req, " dummy"}, rb_bit, 0);
      for (int i = 7; i >= 0; i--) begin
         rb_shift = 1'b1;
         @(negedge clk);
         rb_shift = 1'b0;
         check(rb_bit == exp[i], req, rb_bit, exp[i]);
      end
   endtask

   task automatic read_thr(input logic [7:0] exp, input string req);
      do_op(5'b00001, 8'h00, 1'b0);
      shift_out(exp, req);
   endtask

   task automatic probe(input logic [7:0] a, input bit exp, input string req);
      cand_addr = a;
      #1;
      check(wr_permit == exp, req, wr_permit, exp);
   endtask

   task automatic t_reset();
      check(locked == 0, "R1 locked", locked, 0);
      check(armed == 0, "R1 armed", armed, 0);
      check(rb_bit == 0, "R1 rb_bit", rb_bit, 0);
      check(wall_permit == 1, "R1 wall", wall_permit, 1);
      probe(8'hFF, 1'b1, "R1 permit");
      read_thr(8'hFF, "R9 cleared reads ones");
   endtask

   task automatic t_load();
      do_op(5'b00010, 8'h00, 1'b1);
      check(armed == 1, "R4 arm", armed, 1);
      do_op(5'b01000, 8'h80, 1'b1);
      check(armed == 0, "R5 arm used", armed, 0);
      probe(8'h7F, 1'b1, "R2 below");
      probe(8'h80, 1'b0, "R2 equal");
      probe(8'hFF, 1'b0, "R2 above");
      check(wall_permit == 0, "R3 wall", wall_permit, 0);
      read_thr(8'h80, "R5 load");
      do_op(5'b01000, 8'h40, 1'b1);
      read_thr(8'h80, "R4 no arm");
   endtask

   task automatic t_same_cycle_arm();
      do_op(5'b01010, 8'h40, 1'b1);
      check(armed == 1, "R4 arm same cycle", armed, 1);
      read_thr(8'h80, "R4 load refused");
      do_op(5'b01000, 8'h40, 1'b1);
      read_thr(8'h40, "R4 later load");
   endtask

   task automatic t_pe_low();
      do_op(5'b00010, 8'h00, 1'b0);
      check(armed == 0, "R7 arm pe low", armed, 0);
      do_op(5'b00010, 8'h00, 1'b1);
      do_op(5'b01000, 8'h11, 1'b0);
      read_thr(8'h40, "R7 load pe low");
      do_op(5'b00100, 8'hFF, 1'b0);
      check(wall_permit == 0, "R7 clear pe low", wall_permit, 0);
      do_op(5'b10000, 8'h00, 1'b0);
      check(locked == 0, "R7 lock pe low", locked, 0);
      check(armed == 1, "R7 arm kept", armed, 1);
   endtask

   task automatic t_clear();
      do_op(5'b00100, 8'hFF, 1'b1);
      check(armed == 0, "R6 arm used", armed, 0);
      check(wall_permit == 1, "R6 wall", wall_permit, 1);
      probe(8'hFF, 1'b1, "R6 permit");
      read_thr(8'hFF, "R6 readback");
   endtask

   task automatic t_edges();
      do_op(5'b00010, 8'h00, 1'b1);
      do_op(5'b01000, 8'hFF, 1'b1);
      probe(8'hFE, 1'b1, "R10 254 open");
      probe(8'hFF, 1'b0, "R10 255 shut");
      check(wall_permit == 0, "R3 wall at 255", wall_permit, 0);
      do_op(5'b00010, 8'h00, 1'b1);
      do_op(5'b01000, 8'h00, 1'b1);
      probe(8'h00, 1'b0, "R10 zero shut");
   endtask

   task automatic t_read_during_load();
      do_op(5'b00010, 8'h00, 1'b1);
      do_op(5'b01001, 8'h30, 1'b1);
      shift_out(8'h00, "R11 old value");
      read_thr(8'h30, "R11 new value");
      @(negedge clk);
      op_rd = 1'b1; rb_shift = 1'b1;
      @(negedge clk);
      op_rd = 1'b0; rb_shift = 1'b0;
      shift_out(8'h30, "R12 load wins");
   endtask

   task automatic t_lock();
      do_op(5'b10000, 8'h00, 1'b1);
      check(locked == 1, "R8 lock", locked, 1);
      do_op(5'b00010, 8'h00, 1'b1);
      do_op(5'b01000, 8'h10, 1'b1);
      read_thr(8'h30, "R8 load frozen");
      do_op(5'b00100, 8'hFF, 1'b1);
      check(wall_permit == 0, "R8 clear frozen", wall_permit, 0);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check(locked == 1, "R8 survives reset", locked, 1);
      check(armed == 0, "R1 arm reset", armed, 0);
      read_thr(8'h30, "R8 thr survives");
      @(negedge clk); test_rst_n = 1'b0;
      @(negedge clk); test_rst_n = 1'b1;
      check(locked == 0, "R8 test reset", locked, 0);
      check(wall_permit == 1, "R1 test reset", wall_permit, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1; test_rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_same_cycle_arm();
      t_pe_low();
      t_clear();
      t_edges();
      t_read_during_load();
      t_lock();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule